// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper

This block sits between an 8-bit CPU's 16-bit address bus and the storage of a banked cartridge. It turns each bus address into exactly one target: a 22-bit ROM address, a save-RAM address with a write enable, or a select into 8 KB of work RAM. The lower 48 KB of the address space holds three 16 KB ROM windows. Each window shows a ROM page chosen by its own bank register. The first kilobyte of the lowest window is always pinned to the start of ROM, so the CPU's reset and interrupt vectors cannot be paged away.

Four write-only mapping registers sit in the last four bytes of the address space. A write there updates the register and also goes through to work RAM, which holds the shadow copy that software reads back. The control register can replace the third window with one of two 16 KB save-RAM pages; only that window can then be written. Bank numbers are trimmed by a static mask that matches the ROM size. All outputs follow the address combinationally. No valid/ready handshake exists: the CPU bus completes every access in one cycle and never stalls, so every port is a plain control or data pin.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, the control register is 0 (save RAM off), and windows 0, 1 and 2 show ROM pages 0, 1 and 2.
- R2: Addresses 0x0000-0x03FF always select ROM with rom_addr equal to the bus address, whatever bank window 0 holds.
- R3: Addresses 0x0400-0x3FFF select ROM with rom_addr = {window-0 page, addr[13:0]}.
- R4: Addresses 0x4000-0x7FFF use the window-1 page, and 0x8000-0xBFFF (save RAM off) use the window-2 page, each as {page, addr[13:0]}.
- R5: A write to 0xFFFC loads control bits 3 and 2. Writes to 0xFFFD, 0xFFFE and 0xFFFF load the bank numbers of windows 0, 1 and 2. A new value steers decoding from the cycle after the write edge.
- R6: Every banked page is the stored bank number ANDed with bank_mask.
- R7: With control bit 3 set, 0x8000-0xBFFF selects save RAM with sram_addr = {control bit 2, addr[13:0]}, and sram_we follows cpu_wr there.
- R8: Addresses 0xC000-0xFFFF select work RAM with wram_addr = addr[12:0], so 0xE000 mirrors 0xC000. wram_we follows cpu_wr, including writes to the mapping registers.
- R9: Writes to ROM-mapped addresses raise neither sram_we nor wram_we and change no mapping. Writes to 0xFFFB or below change no mapping either.
- R10: Every address selects exactly one of rom_sel, sram_sel and wram_sel.
- R11: Reads of 0xFFFC-0xFFFF select work RAM at offsets 0x1FFC-0x1FFF, not ROM or save RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_wdata | input | 8 | CPU write data |
| bank_mask | input | 8 | Static page mask from ROM size |
| rom_sel | output | 1 | Access targets ROM |
| rom_addr | output | 22 | ROM byte address |
| sram_sel | output | 1 | Access targets save RAM |
| sram_addr | output | 15 | Save-RAM byte address |
| sram_we | output | 1 | Save-RAM write enable |
| wram_sel | output | 1 | Access targets work RAM |
| wram_addr | output | 13 | Work-RAM byte address |
| wram_we | output | 1 | Work-RAM write enable |

## Verification
Selects, addresses and write enables depend only on the present address and the stored registers, so they are due in the same cycle the address is driven. The bench drives on the falling edge and samples one nanosecond later, before the next rising edge. A register write lands on the rising edge inside its write cycle, so its effect is due in the following cycle. The bench therefore ends each write at the next falling edge and only then presents the probe address. The write enables are sampled within the write cycle itself.

// File: rtl/cart_map_pkg.sv
`timescale 1ns/1ps
package cart_map_pkg;
  localparam int unsigned NUM_WIN = 3;

  typedef enum logic [2:0] {
    RGN_FIXED,
    RGN_WIN0,
    RGN_WIN1,
    RGN_WIN2,
    RGN_WORK
  } region_e;

  typedef struct packed {
    logic save_en;
    logic save_page;
  } ctrl_t;
endpackage

// File: rtl/cart_map_regs.sv
`timescale 1ns/1ps
module cart_map_regs
  import cart_map_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output ctrl_t                          ctrl,
  output logic [NUM_WIN-1:0][BANK_W-1:0] bank
);
  // the four registers occupy the last four bytes of the address space
  logic reg_hit;
  assign reg_hit = wr_en && (&wr_addr[ADDR_W-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (reg_hit && wr_addr[1:0] == 2'd0) begin
      ctrl.save_en   <= wr_data[3];
      ctrl.save_page <= wr_data[2];
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank[w] <= BANK_W'(w);
      end else if (reg_hit && wr_addr[1:0] == 2'(w + 1)) begin
        bank[w] <= BANK_W'(wr_data);
      end
    end
  end
endmodule

// File: rtl/cart_map_decode.sv
`timescale 1ns/1ps
module cart_map_decode
  import cart_map_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_AW  = 14,
  parameter int FIXED_AW = 10
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [PAGE_AW-1:0] offset
);
  assign offset = addr[PAGE_AW-1:0];

  always_comb begin
    unique case (addr[ADDR_W-1:PAGE_AW])
      2'd0:    region = (addr[PAGE_AW-1:FIXED_AW] == '0) ? RGN_FIXED : RGN_WIN0;
      2'd1:    region = RGN_WIN1;
      2'd2:    region = RGN_WIN2;
      default: region = RGN_WORK;
    endcase
  end
endmodule

// File: rtl/cart_bank_mapper.sv
`timescale 1ns/1ps
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int ROM_AW   = 22,
  parameter int PAGE_AW  = 14,
  parameter int FIXED_AW = 10,
  parameter int WRAM_AW  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_wr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic [ROM_AW-PAGE_AW-1:0] bank_mask,
  output logic                    rom_sel,
  output logic [ROM_AW-1:0]       rom_addr,
  output logic                    sram_sel,
  output logic [PAGE_AW:0]        sram_addr,
  output logic                    sram_we,
  output logic                    wram_sel,
  output logic [WRAM_AW-1:0]      wram_addr,
  output logic                    wram_we
);
  localparam int BANK_W = ROM_AW - PAGE_AW;

  ctrl_t                          ctrl;
  logic [NUM_WIN-1:0][BANK_W-1:0] bank;
  region_e                        region;
  logic [PAGE_AW-1:0]             offset;
  logic [BANK_W-1:0]              page;

  cart_map_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .wr_addr(cpu_addr),
    .wr_data(cpu_wdata), .ctrl(ctrl), .bank(bank)
  );

  cart_map_decode #(
    .ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .FIXED_AW(FIXED_AW)
  ) u_dec (
    .addr(cpu_addr), .region(region), .offset(offset)
  );

  always_comb begin
    rom_sel  = 1'b0;
    sram_sel = 1'b0;
    wram_sel = 1'b0;
    page     = '0;
    unique case (region)
      RGN_FIXED: rom_sel = 1'b1;
      RGN_WIN0: begin
        rom_sel = 1'b1;
        page    = bank[0] & bank_mask;
      end
      RGN_WIN1: begin
        rom_sel = 1'b1;
        page    = bank[1] & bank_mask;
      end
      RGN_WIN2: begin
        if (ctrl.save_en) begin
          sram_sel = 1'b1;
        end else begin
          rom_sel = 1'b1;
          page    = bank[2] & bank_mask;
        end
      end
      default: wram_sel = 1'b1;
    endcase
  end

  assign rom_addr  = {page, offset};
  assign sram_addr = {ctrl.save_page, offset};
  assign sram_we   = sram_sel & cpu_wr;
  assign wram_addr = cpu_addr[WRAM_AW-1:0];
  assign wram_we   = wram_sel & cpu_wr;
endmodule

// File: rtl/cart_map_checker.sv
`timescale 1ns/1ps
module cart_map_checker #(
  parameter int ADDR_W  = 16,
  parameter int ROM_AW  = 22,
  parameter int PAGE_AW = 14,
  parameter int WRAM_AW = 13
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         cpu_addr,
  input logic                      cpu_wr,
  input logic [1:0]                ctl_bits,
  input logic [ROM_AW-PAGE_AW-1:0] bank_mask,
  input logic                      rom_sel,
  input logic [ROM_AW-1:0]         rom_addr,
  input logic                      sram_sel,
  input logic [PAGE_AW:0]          sram_addr,
  input logic                      sram_we,
  input logic                      wram_sel,
  input logic [WRAM_AW-1:0]        wram_addr,
  input logic                      wram_we
);
  logic ctl_write;
  assign ctl_write = cpu_wr && (cpu_addr == {{(ADDR_W-2){1'b1}}, 2'b00});

  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_sel, sram_sel, wram_sel}) == 1);

  p_fixed_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:10] == '0) |-> (rom_sel && rom_addr[ROM_AW-1:PAGE_AW] == '0));

  p_rom_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (rom_addr[PAGE_AW-1:0] == cpu_addr[PAGE_AW-1:0]));

  p_page_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> ((rom_addr[ROM_AW-1:PAGE_AW] & ~bank_mask) == '0));

  p_save_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (sram_sel && cpu_wr && sram_addr[PAGE_AW-1:0] == cpu_addr[PAGE_AW-1:0]));

  p_rom_write_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && rom_sel) |-> (!sram_we && !wram_we));

  p_work_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b11) |->
      (wram_sel && wram_addr == cpu_addr[WRAM_AW-1:0] && wram_we == cpu_wr));

  p_ctrl_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write |=> (cpu_addr[ADDR_W-1:ADDR_W-2] != 2'b10 || sram_sel == $past(ctl_bits[1])));

  p_ctrl_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write |=> (sram_addr[PAGE_AW] == $past(ctl_bits[0])));
endmodule

bind cart_bank_mapper cart_map_checker #(
  .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .PAGE_AW(PAGE_AW), .WRAM_AW(WRAM_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .ctl_bits(cpu_wdata[3:2]), .bank_mask(bank_mask), .rom_sel(rom_sel),
  .rom_addr(rom_addr), .sram_sel(sram_sel), .sram_addr(sram_addr),
  .sram_we(sram_we), .wram_sel(wram_sel), .wram_addr(wram_addr),
  .wram_we(wram_we)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  bank_mask = 8'h3F;
  logic        rom_sel, sram_sel, sram_we, wram_sel, wram_we;
  logic [21:0] rom_addr;
  logic [14:0] sram_addr;
  logic [12:0] wram_addr;

  int checks = 0;
  int errors = 0;
  logic seen_sram_we, seen_wram_we;

  always #2.5 clk = ~clk;

  cart_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .bank_mask(bank_mask), .rom_sel(rom_sel),
    .rom_addr(rom_addr), .sram_sel(sram_sel), .sram_addr(sram_addr),
    .sram_we(sram_we), .wram_sel(wram_sel), .wram_addr(wram_addr),
    .wram_we(wram_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write cycle; write enables captured inside the cycle
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    seen_sram_we = sram_we;
    seen_wram_we = wram_we;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    probe(16'h0500); chk("R1 win0 page0", rom_addr, 22'h000500);
    probe(16'h4123); chk("R1 win1 page1", rom_addr, 22'h004123);
    probe(16'h8010); chk("R1 win2 page2", rom_addr, 22'h008010);
    chk("R1 save RAM off", {rom_sel, sram_sel}, 2'b10);
  endtask

  task automatic t_fixed_and_win0;
    bus_write(16'hFFFD, 8'h05);
    probe(16'h0123); chk("R2 fixed kilobyte", rom_addr, 22'h000123);
    probe(16'h03FF); chk("R2 fixed top", rom_addr, 22'h0003FF);
    probe(16'h0400); chk("R3 win0 banked", rom_addr, 22'h014400);
  endtask

  task automatic t_windows;
    bus_write(16'hFFFE, 8'h12);
    bus_write(16'hFFFF, 8'h21);
    probe(16'h5555); chk("R4 R5 win1 page 0x12", rom_addr, 22'h049555);
    probe(16'hA0F0); chk("R4 R5 win2 page 0x21", rom_addr, 22'h0860F0);
  endtask

  task automatic t_mask;
    bank_mask = 8'h0F;
    bus_write(16'hFFFD, 8'h37);
    probe(16'h1000); chk("R6 win0 masked", rom_addr, 22'h01D000);
    probe(16'h4000); chk("R6 win1 masked", rom_addr, 22'h008000);
    bank_mask = 8'h3F;
    probe(16'h1000); chk("R6 wider mask", rom_addr, 22'h0DD000);
  endtask

  task automatic t_save_ram;
    bus_write(16'hFFFC, 8'h08);
    probe(16'h9234);
    chk("R7 save sel", {rom_sel, sram_sel}, 2'b01);
    chk("R7 save addr page0", sram_addr, 15'h1234);
    bus_write(16'hB001, 8'hAA);
    chk("R7 save write enable", seen_sram_we, 1'b1);
    bus_write(16'hFFFC, 8'h0C);
    probe(16'h8001); chk("R7 save addr page1", sram_addr, 15'h4001);
    probe(16'h4000); chk("R7 win1 still ROM", rom_sel, 1'b1);
    bus_write(16'hFFFC, 8'h00);
    probe(16'h8000); chk("R5 save off again", rom_addr, 22'h084000);
  endtask

  task automatic t_work_ram;
    probe(16'hC123); chk("R8 work sel", {wram_sel, wram_addr}, {1'b1, 13'h0123});
    probe(16'hE123); chk("R8 mirror", {wram_sel, wram_addr}, {1'b1, 13'h0123});
    bus_write(16'hFFFE, 8'h12);
    chk("R8 register write reaches work RAM", seen_wram_we, 1'b1);
    probe(16'hFFFC);
    chk("R11 register read from work RAM",
        {rom_sel, sram_sel, wram_sel, wram_addr}, {3'b001, 13'h1FFC});
    probe(16'hFFFF); chk("R11 last register offset", wram_addr, 13'h1FFF);
  endtask

  task automatic t_ignore;
    bus_write(16'h8000, 8'h55);
    chk("R9 ROM write no enables", {seen_sram_we, seen_wram_we}, 2'b00);
    probe(16'hA000); chk("R9 win2 unchanged", rom_addr, 22'h086000);
    bus_write(16'h0000, 8'h09);
    bus_write(16'hFFFB, 8'h09);
    probe(16'h0400); chk("R9 win0 unchanged", rom_addr, 22'h0DC400);
  endtask

  task automatic t_one_target;
    logic [15:0] pts [8] = '{16'h0000, 16'h03FF, 16'h0400, 16'h7FFF,
                             16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
    for (int i = 0; i < 8; i++) begin
      probe(pts[i]);
      chk("R10 exactly one target", $countones({rom_sel, sram_sel, wram_sel}), 1);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed_and_win0();
    t_windows();
    t_mask();
    t_save_ram();
    t_work_ram();
    t_ignore();
    t_one_target();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule